// File: doc/BRIEF.md
# BCD Calendar Counter With Hold

This block keeps time of day and date as thirteen BCD digits: seconds, minutes, hours, day of month, month, a two-digit year and a day of week. An internal prescaler divides a 16.384 kHz enable input down to a one-second tick, and each tick advances the chain with full carry propagation from seconds to year in one clock cycle. Hours run either in 24-hour form or in 12-hour form (12, 1 … 11) with a separate afternoon flag. Leap years are handled on the two-digit year. A date that cannot exist is pushed to the 1st of the next month when the next day carry arrives.

Software reaches the digits through a simple register port of one 4-bit digit per address. To read or write a consistent time it raises the hold input. This freezes the seconds carry. One missed tick is remembered and applied when hold drops, and any further missed ticks are lost. A busy output shows whether the counters may still move. Stop freezes the prescaler. Sub-second reset clears it and keeps it cleared. A 30-second adjust input rounds the time to the nearest minute. One-cycle carry pulses for seconds, minutes and hours drive a neighbouring interrupt block.

Within one cycle a register write to a digit overrides that digit's advance, and an adjust request overrides a concurrent second tick.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, the day and month read 01, the year reads 00, the weekday reads 0, busy is 1 and no carry pulse is active.
- R2: Seconds and minutes count in BCD: units digit (addresses 0 and 2) 0 to 9, tens digit (addresses 1 and 3) 0 to 5. Seconds 59 rolls to 00 and carries into minutes, and minutes 59 carries into hours.
- R3: With mode24_i = 1 the hour runs 00 to 23. At address 5, bit 0 is hour-ten and bit 1 is hour-twenty. The afternoon bit (bit 2) reads 0, and a write to it is dropped.
- R4: With mode24_i = 0 the hour runs 12, 1 … 11. Address 5 bit 2 is the afternoon flag, which toggles when 11 becomes 12. Bit 1 reads 0. The day carry happens when 11 with the flag set becomes 12 with the flag clear.
- R5: The day carry rolls the last day of a month to 01 and advances the month. Month 12 rolls to 01 and advances the year, and year 99 rolls to 00. Months 4, 6, 9 and 11 have 30 days, month 2 has 28 or 29, and the others have 31.
- R6: A year whose two-digit value is divisible by 4 is a leap year: February 28 advances to 29 and February 29 to March 1. In other years February 28 advances to March 1.
- R7: A written date past the month's end keeps its written value until the next day carry, which sets it to the 1st of the following month.
- R8: The weekday (address 12) counts 0 to 6 and wraps to 0, advancing once per day carry.
- R9: While hold_i is 1, second ticks do not change the counters. When hold_i returns to 0 after one or more missed ticks, the time advances by exactly one second. With no missed tick, release changes nothing.
- R10: busy_o is 0 from the cycle after hold_i is sampled 1, and is 1 from the cycle after hold_i is sampled 0.
- R11: While stop_i is 1, enable pulses are ignored by the prescaler. While sub_rst_i is 1, the prescaler is cleared, so a full PRESCALE_DIV enables are needed after release before the next second.
- R12: A one-cycle adj_i pulse sets the seconds to 00. If the seconds were 30 or more, it also advances the minute with full carry. Otherwise the minutes are unchanged.
- R13: sec_p_o pulses for one cycle with each one-second advance (not for adjust). min_p_o pulses when the minutes change by counting, and hr_p_o pulses when the hours change by counting. Each pulse coincides with the updated counters.
- R14: Addresses 0 to 12 in order are: seconds units, seconds tens, minutes units, minutes tens, hour units, hour tens/flag, day units, day tens, month units, month tens, year units, year tens, weekday. Bits outside a digit's field are dropped on write and read 0 (seconds and minutes tens and weekday 3 bits, day tens 2 bits, month tens 1 bit). Addresses 13 to 15 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 16.384 kHz enable pulse feeding the prescaler |
| stop_i | input | 1 | Freeze the prescaler |
| sub_rst_i | input | 1 | Clear and hold the sub-second prescaler |
| hold_i | input | 1 | Block second carries for consistent access |
| mode24_i | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode |
| adj_i | input | 1 | One-cycle request for 30-second rounding |
| wr_en_i | input | 1 | Digit write strobe |
| wr_addr_i | input | ADDR_W | Digit write address |
| wr_data_i | input | DATA_W | Digit write data |
| rd_addr_i | input | ADDR_W | Digit read address |
| rd_data_o | output | DATA_W | Masked digit at rd_addr_i (combinational) |
| busy_o | output | 1 | 0 while the counters are held stable |
| sec_p_o | output | 1 | One-cycle pulse per second advance |
| min_p_o | output | 1 | One-cycle pulse when minutes advance |
| hr_p_o | output | 1 | One-cycle pulse when hours advance |

## Verification
The assertions assume that software writes only in-range BCD values. They also assume that a digit is not written in the same cycle that a tick or adjust moves it, and that adjust is not raised while the seconds digits are being written. Under those conditions the seconds stay frozen under hold, an adjust leaves 00 seconds, and every seconds pulse goes with a change of the seconds digit. The bench keeps to these assumptions. It writes only legal digit values except in the field-masking checks, and those use digits that are not counting at the time. It puts writes, enable pulses, adjust requests and hold edges in separate cycles, and feeds enables in groups of PRESCALE_DIV so the prescaler phase is known at every check.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int DIG_COUNT = 13;
   localparam int NIB_W     = 4;

   localparam int IX_S1   = 0;
   localparam int IX_S10  = 1;
   localparam int IX_MI1  = 2;
   localparam int IX_MI10 = 3;
   localparam int IX_H1   = 4;
   localparam int IX_H10  = 5;
   localparam int IX_D1   = 6;
   localparam int IX_D10  = 7;
   localparam int IX_MO1  = 8;
   localparam int IX_MO10 = 9;
   localparam int IX_Y1   = 10;
   localparam int IX_Y10  = 11;
   localparam int IX_WK   = 12;

   typedef logic [DIG_COUNT-1:0][NIB_W-1:0] digits_t;

   // legal bits of each digit; the hour-tens field depends on the hour mode
   function automatic logic [NIB_W-1:0] field_mask(input int idx, input logic m24);
      case (idx)
         IX_S10, IX_MI10, IX_WK: field_mask = 4'b0111;
         IX_H10:                 field_mask = m24 ? 4'b0011 : 4'b0101;
         IX_D10:                 field_mask = 4'b0011;
         IX_MO10:                field_mask = 4'b0001;
         default:                field_mask = 4'b1111;
      endcase
   endfunction

   function automatic logic [NIB_W-1:0] reset_value(input int idx);
      reset_value = (idx == IX_D1 || idx == IX_MO1) ? 4'd1 : 4'd0;
   endfunction

   function automatic logic [6:0] bcd2bin(input logic [3:0] tens, input logic [3:0] units);
      bcd2bin = 7'(tens) * 7'd10 + 7'(units);
   endfunction

   function automatic logic [6:0] month_len(input logic [6:0] mon, input logic leap);
      case (mon)
         7'd2:                    month_len = leap ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11: month_len = 7'd30;
         default:                 month_len = 7'd31;
      endcase
   endfunction
endpackage

// File: rtl/cal_prescale.sv
module cal_prescale #(
   parameter int DIV = 16384
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic stop_i,
   input  logic clr_i,
   output logic tick_o
);
   localparam int  CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = ((1 << CW) == DIV);

   logic [CW-1:0] cnt_q;
   logic          adv;

   assign adv = en_i & ~stop_i & ~clr_i;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("cal_prescale: DIV must be at least 2");
      end
      if (POW2) begin : g_pow2
         // free-running wrap, terminal count is all ones
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (adv)    cnt_q <= cnt_q + CW'(1);
         end
         assign tick_o = adv & (&cnt_q);
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt_q <= '0;
            else if (clr_i)  cnt_q <= '0;
            else if (adv)    cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + CW'(1);
         end
         assign tick_o = adv & (cnt_q == CW'(DIV - 1));
      end
   endgenerate

   // R11
   stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !clr_i) |=> $stable(cnt_q));
   // R11
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/cal_hold.sv
module cal_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic tick_i,
   output logic step_o,
   output logic busy_o
);
   logic hold_q, pend_q, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         pend_q <= 1'b0;
         busy_q <= 1'b1;
      end else begin
         hold_q <= hold_i;
         busy_q <= ~hold_i;
         if (!hold_i)     pend_q <= 1'b0;
         else if (tick_i) pend_q <= 1'b1;
      end
   end

   // a live tick, or the single remembered tick in the release cycle
   assign step_o = ~hold_i & (tick_i | (hold_q & pend_q));
   assign busy_o = busy_q;

   // R10
   busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !busy_o);
   // R10
   busy_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_i |=> busy_o);
endmodule

// File: rtl/cal_advance.sv
module cal_advance
   import cal_pkg::*;
(
   input  digits_t cur_i,
   input  logic    mode24_i,
   input  logic    adj_i,
   output digits_t nxt_o,
   output logic    min_adv_o,
   output logic    hr_adv_o
);
   logic       sec_c, min_c, day_c, mon_c, yr_c, pm, leap;
   logic [6:0] day_v, mon_v, dim;
   digits_t    nxt;

   always_comb begin
      nxt   = cur_i;
      sec_c = 1'b0;
      min_c = 1'b0;
      day_c = 1'b0;
      mon_c = 1'b0;
      yr_c  = 1'b0;
      pm    = cur_i[IX_H10][2];
      day_v = bcd2bin(cur_i[IX_D10], cur_i[IX_D1]);
      mon_v = bcd2bin(cur_i[IX_MO10], cur_i[IX_MO1]);
      leap  = ((bcd2bin(cur_i[IX_Y10], cur_i[IX_Y1]) % 7'd4) == 7'd0);
      dim   = month_len(mon_v, leap);

      // seconds: rounding adjust or one-second increment
      if (adj_i) begin
         nxt[IX_S1]  = 4'd0;
         nxt[IX_S10] = 4'd0;
         sec_c       = (cur_i[IX_S10] >= 4'd3);
      end else if (cur_i[IX_S1] == 4'd9) begin
         nxt[IX_S1] = 4'd0;
         if (cur_i[IX_S10] == 4'd5) begin
            nxt[IX_S10] = 4'd0;
            sec_c       = 1'b1;
         end else begin
            nxt[IX_S10] = cur_i[IX_S10] + 4'd1;
         end
      end else begin
         nxt[IX_S1] = cur_i[IX_S1] + 4'd1;
      end

      // minutes
      if (sec_c) begin
         if (cur_i[IX_MI1] == 4'd9) begin
            nxt[IX_MI1] = 4'd0;
            if (cur_i[IX_MI10] == 4'd5) begin
               nxt[IX_MI10] = 4'd0;
               min_c        = 1'b1;
            end else begin
               nxt[IX_MI10] = cur_i[IX_MI10] + 4'd1;
            end
         end else begin
            nxt[IX_MI1] = cur_i[IX_MI1] + 4'd1;
         end
      end

      // hours
      if (min_c) begin
         if (mode24_i) begin
            if (cur_i[IX_H10][1:0] == 2'd2 && cur_i[IX_H1] == 4'd3) begin
               nxt[IX_H10] = 4'd0;
               nxt[IX_H1]  = 4'd0;
               day_c       = 1'b1;
            end else if (cur_i[IX_H1] == 4'd9) begin
               nxt[IX_H1]  = 4'd0;
               nxt[IX_H10] = {2'b00, cur_i[IX_H10][1:0] + 2'd1};
            end else begin
               nxt[IX_H1] = cur_i[IX_H1] + 4'd1;
            end
         end else begin
            if (cur_i[IX_H10][0] && cur_i[IX_H1] == 4'd1) begin
               nxt[IX_H1]  = 4'd2;
               nxt[IX_H10] = {1'b0, ~pm, 2'b01};
               day_c       = pm;
            end else if (cur_i[IX_H10][0] && cur_i[IX_H1] == 4'd2) begin
               nxt[IX_H1]  = 4'd1;
               nxt[IX_H10] = {1'b0, pm, 2'b00};
            end else if (cur_i[IX_H1] == 4'd9) begin
               nxt[IX_H1]  = 4'd0;
               nxt[IX_H10] = {1'b0, pm, 2'b01};
            end else begin
               nxt[IX_H1] = cur_i[IX_H1] + 4'd1;
            end
         end
      end

      // day and weekday; out-of-range dates land on the 1st of next month
      if (day_c) begin
         nxt[IX_WK] = (cur_i[IX_WK] >= 4'd6) ? 4'd0 : cur_i[IX_WK] + 4'd1;
         if (day_v >= dim) begin
            nxt[IX_D1]  = 4'd1;
            nxt[IX_D10] = 4'd0;
            mon_c       = 1'b1;
         end else if (cur_i[IX_D1] == 4'd9) begin
            nxt[IX_D1]  = 4'd0;
            nxt[IX_D10] = cur_i[IX_D10] + 4'd1;
         end else begin
            nxt[IX_D1] = cur_i[IX_D1] + 4'd1;
         end
      end

      // month
      if (mon_c) begin
         if (mon_v >= 7'd12) begin
            nxt[IX_MO1]  = 4'd1;
            nxt[IX_MO10] = 4'd0;
            yr_c         = 1'b1;
         end else if (cur_i[IX_MO1] == 4'd9) begin
            nxt[IX_MO1]  = 4'd0;
            nxt[IX_MO10] = 4'd1;
         end else begin
            nxt[IX_MO1] = cur_i[IX_MO1] + 4'd1;
         end
      end

      // year
      if (yr_c) begin
         if (cur_i[IX_Y1] == 4'd9) begin
            nxt[IX_Y1]  = 4'd0;
            nxt[IX_Y10] = (cur_i[IX_Y10] == 4'd9) ? 4'd0 : cur_i[IX_Y10] + 4'd1;
         end else begin
            nxt[IX_Y1] = cur_i[IX_Y1] + 4'd1;
         end
      end
   end

   assign nxt_o     = nxt;
   assign min_adv_o = sec_c;
   assign hr_adv_o  = min_c;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import cal_pkg::*;
#(
   parameter int PRESCALE_DIV = 16384,
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en_i,
   input  logic              stop_i,
   input  logic              sub_rst_i,
   input  logic              hold_i,
   input  logic              mode24_i,
   input  logic              adj_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              busy_o,
   output logic              sec_p_o,
   output logic              min_p_o,
   output logic              hr_p_o
);
   localparam int MIN_ADDR_W = $clog2(DIG_COUNT);

   generate
      if (DATA_W != NIB_W) begin : g_bad_data
         $error("bcd_calendar: DATA_W must equal the BCD digit width");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
         $error("bcd_calendar: ADDR_W too narrow for the digit map");
      end
   endgenerate

   logic       sec_tick, step, adv_en, min_adv, hr_adv;
   logic       sec_p_q, min_p_q, hr_p_q;
   logic [NIB_W-1:0] dig_q [DIG_COUNT];
   digits_t    cur_w, nxt_w;

   cal_prescale #(.DIV(PRESCALE_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (tick_en_i),
      .stop_i (stop_i),
      .clr_i  (sub_rst_i),
      .tick_o (sec_tick)
   );

   cal_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (hold_i),
      .tick_i (sec_tick),
      .step_o (step),
      .busy_o (busy_o)
   );

   always_comb begin
      for (int k = 0; k < DIG_COUNT; k++) cur_w[k] = dig_q[k];
   end

   cal_advance u_adv (
      .cur_i     (cur_w),
      .mode24_i  (mode24_i),
      .adj_i     (adj_i),
      .nxt_o     (nxt_w),
      .min_adv_o (min_adv),
      .hr_adv_o  (hr_adv)
   );

   assign adv_en = step | adj_i;

   // one register per digit: a port write wins over the counting update
   for (genvar i = 0; i < DIG_COUNT; i++) begin : g_dig
      localparam logic [NIB_W-1:0] RST_V = reset_value(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dig_q[i] <= RST_V;
         else if (wr_en_i && wr_addr_i == ADDR_W'(i))
            dig_q[i] <= wr_data_i & field_mask(i, mode24_i);
         else if (adv_en)
            dig_q[i] <= nxt_w[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_p_q <= 1'b0;
         min_p_q <= 1'b0;
         hr_p_q  <= 1'b0;
      end else begin
         sec_p_q <= step & ~adj_i;
         min_p_q <= adv_en & min_adv;
         hr_p_q  <= adv_en & hr_adv;
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < DIG_COUNT; k++) begin
         if (rd_addr_i == ADDR_W'(k)) rd_data_o = dig_q[k] & field_mask(k, mode24_i);
      end
   end

   assign sec_p_o = sec_p_q;
   assign min_p_o = min_p_q;
   assign hr_p_o  = hr_p_q;

   // R9
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !adj_i && !wr_en_i) |=> ($stable(dig_q[IX_S1]) && $stable(dig_q[IX_S10])));
   // R12
   adjust_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_i && !wr_en_i) |=> (dig_q[IX_S1] == 4'd0 && dig_q[IX_S10] == 4'd0));
   // R13
   sec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_p_o |-> (dig_q[IX_S1] != $past(dig_q[IX_S1])));
   // R13
   hr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hr_p_o |-> (dig_q[IX_H1] != $past(dig_q[IX_H1])));
endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
   localparam int DIV = 4;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       tick_en = 0, stop = 0, sub_rst = 0, hold = 0, mode24 = 1, adj = 0;
   logic       wr_en = 0;
   logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
   logic       busy, sec_p, min_p, hr_p;

   int n_chk = 0, n_fail = 0;
   int sec_cnt = 0, min_cnt = 0, hr_cnt = 0;
   int s0, m0, h0;

   logic [3:0] exp_q[$];
   logic [3:0] adr_q[$];
   int         req_q[$];
   logic [3:0] m_exp, m_adr;
   int         m_req;

   always #10 clk = ~clk;

   bcd_calendar #(.PRESCALE_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .stop_i(stop),
      .sub_rst_i(sub_rst), .hold_i(hold), .mode24_i(mode24), .adj_i(adj),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy),
      .sec_p_o(sec_p), .min_p_o(min_p), .hr_p_o(hr_p)
   );

   // pulse counters
   always @(negedge clk) begin
      if (sec_p) sec_cnt++;
      if (min_p) min_cnt++;
      if (hr_p)  hr_cnt++;
   end

   // scoreboard monitor: pops one expected read per cycle
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         m_exp = exp_q.pop_front();
         m_adr = adr_q.pop_front();
         m_req = req_q.pop_front();
         n_chk++;
         if (rd_data !== m_exp) begin
            n_fail++;
            $display("FAIL R%0d addr %0d: got %h expected %h", m_req, m_adr, rd_data, m_exp);
         end
      end
   end

   task automatic chk_rd(input logic [3:0] a, input logic [3:0] e, input int r);
      @(posedge clk); #1;
      rd_addr = a;
      adr_q.push_back(a);
      exp_q.push_back(e);
      req_q.push_back(r);
      @(negedge clk); #1;
   endtask

   task automatic chk_val(input int got, input int expv, input int r, input string what);
      n_chk++;
      if (got != expv) begin
         n_fail++;
         $display("FAIL R%0d %s: got %0d expected %0d", r, what, got, expv);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [3:0] d);
      @(posedge clk); #1;
      wr_en = 1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic tick1();
      @(posedge clk); #1; tick_en = 1;
      @(posedge clk); #1; tick_en = 0;
   endtask

   task automatic one_sec();
      repeat (DIV) tick1();
   endtask

   task automatic do_adj();
      @(posedge clk); #1; adj = 1;
      @(posedge clk); #1; adj = 0;
   endtask

   task automatic set_t(input logic [3:0] h10, h1, m10, m1, s10, s1);
      wr(5, h10); wr(4, h1); wr(3, m10); wr(2, m1); wr(1, s10); wr(0, s1);
   endtask

   task automatic set_d(input logic [3:0] d10, d1, mo10, mo1, y10, y1, wk);
      wr(7, d10); wr(6, d1); wr(9, mo10); wr(8, mo1); wr(11, y10); wr(10, y1); wr(12, wk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      chk_rd(0, 4'd0, 1); chk_rd(1, 4'd0, 1); chk_rd(4, 4'd0, 1); chk_rd(5, 4'd0, 1);
      chk_rd(6, 4'd1, 1); chk_rd(8, 4'd1, 1); chk_rd(10, 4'd0, 1); chk_rd(12, 4'd0, 1);
      chk_val(busy, 1, 1, "busy after reset");
      chk_val(sec_cnt + min_cnt + hr_cnt, 0, 1, "pulses after reset");

      // R2 R3 R5 R8 R13: full rollover 23:59:58 Dec 31 year 99, weekday 6
      set_t(2, 3, 5, 9, 5, 8);
      set_d(3, 1, 1, 2, 9, 9, 6);
      one_sec();
      chk_rd(0, 4'd9, 2);
      s0 = sec_cnt; m0 = min_cnt; h0 = hr_cnt;
      one_sec();
      chk_rd(0, 4'd0, 2); chk_rd(1, 4'd0, 2); chk_rd(2, 4'd0, 2); chk_rd(3, 4'd0, 2);
      chk_rd(4, 4'd0, 3); chk_rd(5, 4'd0, 3);
      chk_rd(6, 4'd1, 5); chk_rd(7, 4'd0, 5); chk_rd(8, 4'd1, 5); chk_rd(9, 4'd0, 5);
      chk_rd(10, 4'd0, 5); chk_rd(11, 4'd0, 5);
      chk_rd(12, 4'd0, 8);
      chk_val(sec_cnt - s0, 1, 13, "seconds pulses");
      chk_val(min_cnt - m0, 1, 13, "minute pulses");
      chk_val(hr_cnt - h0, 1, 13, "hour pulses");

      // R3: 09:59:59 -> 10:00:00
      set_t(0, 9, 5, 9, 5, 9);
      one_sec();
      chk_rd(5, 4'd1, 3); chk_rd(4, 4'd0, 3); chk_rd(6, 4'd1, 3);

      // R4: 12-hour mode, 11 AM -> 12 PM -> 1 PM
      @(posedge clk); #1 mode24 = 0;
      set_t(4'b0001, 1, 5, 9, 5, 9);
      one_sec();
      chk_rd(5, 4'b0101, 4); chk_rd(4, 4'd2, 4);
      wr(3, 5); wr(2, 9); wr(1, 5); wr(0, 9);
      one_sec();
      chk_rd(5, 4'b0100, 4); chk_rd(4, 4'd1, 4);
      // R4 R6 R8: 11 PM Feb 28 year 23 -> 12 AM Mar 1, weekday 3 -> 4
      set_t(4'b0101, 1, 5, 9, 5, 9);
      set_d(2, 8, 0, 2, 2, 3, 3);
      one_sec();
      chk_rd(5, 4'b0001, 4); chk_rd(4, 4'd2, 4);
      chk_rd(6, 4'd1, 6); chk_rd(7, 4'd0, 6); chk_rd(8, 4'd3, 6); chk_rd(9, 4'd0, 6);
      chk_rd(12, 4'd4, 8);
      // R4 R14: hour-twenty bit dropped in 12-hour mode
      wr(5, 4'b0111);
      chk_rd(5, 4'b0101, 4);
      @(posedge clk); #1 mode24 = 1;

      // R6: leap year 24, Feb 28 -> 29 -> Mar 1
      set_t(2, 3, 5, 9, 5, 9);
      set_d(2, 8, 0, 2, 2, 4, 0);
      one_sec();
      chk_rd(7, 4'd2, 6); chk_rd(6, 4'd9, 6); chk_rd(8, 4'd2, 6);
      set_t(2, 3, 5, 9, 5, 9);
      one_sec();
      chk_rd(6, 4'd1, 6); chk_rd(8, 4'd3, 6);

      // R7: Nov 31 stays until the day carry, then Dec 1
      set_t(2, 3, 5, 9, 5, 9);
      set_d(3, 1, 1, 1, 8, 3, 2);
      chk_rd(7, 4'd3, 7);
      one_sec();
      chk_rd(7, 4'd0, 7); chk_rd(6, 4'd1, 7); chk_rd(9, 4'd1, 7); chk_rd(8, 4'd2, 7);
      // R7: Feb 29 in common year 83 -> Mar 1
      set_t(2, 3, 5, 9, 5, 9);
      set_d(2, 9, 0, 2, 8, 3, 2);
      one_sec();
      chk_rd(6, 4'd1, 7); chk_rd(8, 4'd3, 7); chk_rd(9, 4'd0, 7);

      // R3 R14: field masking and unmapped addresses
      wr(5, 4'b0111);
      chk_rd(5, 4'b0011, 3);
      wr(1, 4'hF);
      chk_rd(1, 4'd7, 14);
      wr(9, 4'hF);
      chk_rd(9, 4'd1, 14);
      wr(13, 4'd5);
      chk_rd(13, 4'd0, 14);

      // R12: adjust below 30 s, then at 45 s with minute carry
      set_t(0, 0, 0, 9, 2, 9);
      s0 = sec_cnt; m0 = min_cnt;
      do_adj();
      chk_rd(0, 4'd0, 12); chk_rd(1, 4'd0, 12); chk_rd(2, 4'd9, 12);
      wr(1, 4); wr(0, 5);
      do_adj();
      chk_rd(0, 4'd0, 12); chk_rd(1, 4'd0, 12); chk_rd(2, 4'd0, 12); chk_rd(3, 4'd1, 12);
      chk_val(min_cnt - m0, 1, 13, "adjust minute pulse");
      chk_val(sec_cnt - s0, 0, 13, "adjust gives no seconds pulse");

      // R9 R10: hold with three missed seconds gives one catch-up
      wr(1, 1); wr(0, 0);
      @(posedge clk); #1 hold = 1;
      @(posedge clk); @(negedge clk);
      chk_val(busy, 0, 10, "busy under hold");
      repeat (3) one_sec();
      chk_rd(0, 4'd0, 9);
      @(posedge clk); #1 hold = 0;
      chk_rd(0, 4'd1, 9); chk_rd(1, 4'd1, 9);
      chk_val(busy, 1, 10, "busy after release");
      one_sec();
      chk_rd(0, 4'd2, 9);
      // R9: hold without a missed tick
      @(posedge clk); #1 hold = 1;
      repeat (3) @(posedge clk);
      #1 hold = 0;
      repeat (2) @(posedge clk);
      chk_rd(0, 4'd2, 9);

      // R11: stop ignores enables
      @(posedge clk); #1 stop = 1;
      repeat (2 * DIV) tick1();
      chk_rd(0, 4'd2, 11);
      @(posedge clk); #1 stop = 0;
      one_sec();
      chk_rd(0, 4'd3, 11);

      // R11: sub-second reset restarts the prescaler
      repeat (DIV - 1) tick1();
      @(posedge clk); #1 sub_rst = 1;
      @(posedge clk); #1 sub_rst = 0;
      repeat (DIV - 1) tick1();
      chk_rd(0, 4'd3, 11);
      tick1();
      chk_rd(0, 4'd4, 11);

      repeat (3) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule